// File: doc/BRIEF.md
# Contactless Reader Command Sequencer

This block is the command controller of a contactless reader front end. A host writes a 4-bit command code. The block then runs one of three jobs over a shared byte FIFO and two simple engine handshakes. The jobs are a single receive, an endless transmit/receive loop, and an authentication job. The authentication job streams twelve FIFO bytes to an external cipher engine.

Commands stop under different rules. A receive stops by itself when its frame ends. The transmit/receive loop stops only when the host writes another command. With the multi-frame flag set, no receive phase ever ends by itself. Every transmission in the loop waits for a host start-send bit. While authentication runs, host FIFO traffic is refused and flagged. Frame ends come either from an end-of-frame strobe or from a length byte at the start of the frame. The `len_mode` input selects which.

Top module: `rfcmd_seq`

## Requirements
- R1: Command codes are 4'h8 receive, 4'hC transceive and 4'hE authenticate. Any other code, 4'h0 included, returns the block to idle. A command write acts at the next clock edge, replaces whatever is running, and `idle` is high exactly when no command is active. Out of reset, `idle` is high and every strobe and flag is low.
- R2: A receive write raises `rx_start` for one cycle just after the edge. With `len_mode` low and `multi_rx` low, an `rx_eof` ends the receive. `idle` is then high and `irq_idle` pulses for one cycle, both in the cycle after the edge that sampled `rx_eof`.
- R3: With `len_mode` high, the first `rx_byte` of a frame is a count N, and the frame ends on the Nth byte that follows it. With N = 0 the frame ends on the count byte itself. `rx_eof` has no effect in this mode.
- R4: With `multi_rx` high, a frame end does not end a receive. The command stays active with no `irq_idle` until the next command write.
- R5: Transceive first waits without transmitting. `tx_start` pulses for one cycle in the cycle after one in which the job was waiting and the start-send bit was set.
- R6: A `send_set` pulse sets the start-send bit, and each transmit launch clears it. A `send_set` in the same cycle as a launch is kept for the next transmission.
- R7: After `tx_done`, `rx_start` pulses in the next cycle. With `multi_rx` low, a frame end returns the job to waiting for start-send. Transceive never goes idle by itself.
- R8: With `multi_rx` high, transceive stays in its receive phase after frame ends, and further `send_set` pulses launch no transmission.
- R9: Authentication first checks two conditions: `fifo_level` must be at least 12 and `fifo_head` must be 8'h60 or 8'h61. If either fails, `err_auth` is set and the block returns to idle. No byte is streamed and `irq_idle` stays low.
- R10: After a passing check, `auth_vld` and `fifo_pop` are high for 12 consecutive cycles. `auth_byte` equals the FIFO head in each of those cycles, and `auth_last` marks the twelfth. The block then waits for `auth_done`, which makes it idle and pulses `irq_idle`.
- R11: From the cycle after an authenticate write until the block leaves authentication, `host_rd_gnt` and `host_wr_gnt` are low, and any `host_rd` or `host_wr` sets `err_wr`. At other times each grant follows its request in the same cycle.
- R12: `err_wr` and `err_auth` hold until a command write clears them. A set in the same cycle as a clearing write wins.
- R13: When a command write falls in the same cycle as a frame end or `auth_done`, the write wins. The new command takes over and `irq_idle` does not pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_we | input | 1 | Command register write strobe |
| cmd_code | input | 4 | Command code written with `cmd_we` |
| send_set | input | 1 | Host pulse that sets the start-send bit |
| multi_rx | input | 1 | Multi-frame receive enable |
| len_mode | input | 1 | Frame end taken from a leading length byte instead of `rx_eof` |
| host_rd | input | 1 | Host FIFO read request |
| host_wr | input | 1 | Host FIFO write request |
| host_rd_gnt | output | 1 | Host read allowed to reach the FIFO |
| host_wr_gnt | output | 1 | Host write allowed to reach the FIFO |
| fifo_level | input | LVL_W | Bytes held in the FIFO |
| fifo_head | input | 8 | Byte at the FIFO head (first-word fall-through) |
| fifo_pop | output | 1 | Pop the FIFO head for the authentication stream |
| tx_start | output | 1 | One-cycle launch of the transmit engine |
| tx_done | input | 1 | Transmit engine finished |
| rx_start | output | 1 | One-cycle launch of the receive engine |
| rx_byte_vld | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_eof | input | 1 | End-of-frame from the receive engine |
| auth_vld | output | 1 | Authentication byte valid |
| auth_byte | output | 8 | Authentication byte |
| auth_last | output | 1 | Twelfth authentication byte |
| auth_done | input | 1 | Authentication engine finished |
| idle | output | 1 | No command active |
| irq_idle | output | 1 | One-cycle pulse when a command ends by itself |
| err_wr | output | 1 | Host touched the FIFO during authentication |
| err_auth | output | 1 | Authentication refused at its start check |

## Verification
A host command write can land in the same cycle as an automatic end: either a frame end during receive, or `auth_done` during the authentication wait. The bench drives `cmd_we` in the very cycle that carries `rx_eof` or `auth_done`. It also adds a refused host write in that cycle, so that an error set meets an error clear. The behavioural model expects the newly written command to take effect, `irq_idle` to stay low, and `err_wr` to end up set. These expectations are compared on every clock.

// File: rtl/rfcmd_pkg.sv
package rfcmd_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    CMD_IDLE = 4'h0,
    CMD_RECV = 4'h8,
    CMD_XCV  = 4'hC,
    CMD_AUTH = 4'hE
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_XWAIT,
    ST_XSEND,
    ST_XRECV,
    ST_ACHK,
    ST_ASEND,
    ST_AWAIT
  } seq_st_e;

  localparam logic [BYTE_W-1:0] AUTH_HDR_A = 8'h60;
  localparam logic [BYTE_W-1:0] AUTH_HDR_B = 8'h61;

endpackage

// File: rtl/rfcmd_rx_track.sv
module rfcmd_rx_track
  import rfcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              clear,
  input  logic              len_mode,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              eof,
  output logic              frame_end
);

  logic              have_q, have_d;
  logic [BYTE_W-1:0] rem_q, rem_d;

  always_comb begin
    if (len_mode)
      frame_end = active & byte_vld &
                  (have_q ? (rem_q == BYTE_W'(1)) : (byte_in == '0));
    else
      frame_end = active & eof;
    have_d = have_q;
    rem_d  = rem_q;
    if (clear || !active || frame_end) begin
      have_d = 1'b0;
    end else if (len_mode && byte_vld) begin
      if (!have_q) begin
        have_d = 1'b1;
        rem_d  = byte_in;
      end else begin
        rem_d = rem_q - BYTE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      rem_q  <= '0;
    end else begin
      have_q <= have_d;
      rem_q  <= rem_d;
    end
  end

  // R3
  len_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && len_mode && byte_vld && have_q && !frame_end && !clear)
      |=> (rem_q == $past(rem_q) - BYTE_W'(1)));

endmodule

// File: rtl/rfcmd_auth_stream.sv
module rfcmd_auth_stream
  import rfcmd_pkg::*;
#(
  parameter int LVL_W      = 7,
  parameter int AUTH_BYTES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [BYTE_W-1:0] fifo_head,
  output logic              hdr_ok,
  output logic              auth_vld,
  output logic [BYTE_W-1:0] auth_byte,
  output logic              auth_last,
  output logic              fifo_pop
);

  localparam int CNT_W = $clog2(AUTH_BYTES);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    hdr_ok    = (fifo_level >= LVL_W'(AUTH_BYTES)) &&
                ((fifo_head == AUTH_HDR_A) || (fifo_head == AUTH_HDR_B));
    auth_vld  = run;
    fifo_pop  = run;
    auth_byte = fifo_head;
    auth_last = run && (cnt_q == CNT_W'(AUTH_BYTES - 1));
    cnt_d     = run ? cnt_q + CNT_W'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10
  first_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(auth_vld) |-> ((auth_byte == AUTH_HDR_A) || (auth_byte == AUTH_HDR_B)));

  // R10
  last_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    auth_last |=> !auth_vld);

endmodule

// File: rtl/rfcmd_host_guard.sv
module rfcmd_host_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic lock,
  input  logic clr,
  input  logic host_rd,
  input  logic host_wr,
  output logic rd_gnt,
  output logic wr_gnt,
  output logic err_wr
);

  logic hit;
  logic err_en;
  logic err_d;

  always_comb begin
    rd_gnt = host_rd & ~lock;
    wr_gnt = host_wr & ~lock;
    hit    = lock & (host_rd | host_wr);
    err_en = hit | clr;
    err_d  = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_wr <= 1'b0;
    else if (err_en) err_wr <= err_d;
  end

  // R11
  lock_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && (host_rd || host_wr)) |=> err_wr);

  // R12
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_wr && !clr) |=> err_wr);

endmodule

// File: rtl/rfcmd_seq.sv
module rfcmd_seq
  import rfcmd_pkg::*;
#(
  parameter int LVL_W      = 7,
  parameter int AUTH_BYTES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [3:0]        cmd_code,
  input  logic              send_set,
  input  logic              multi_rx,
  input  logic              len_mode,
  input  logic              host_rd,
  input  logic              host_wr,
  output logic              host_rd_gnt,
  output logic              host_wr_gnt,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic [BYTE_W-1:0] fifo_head,
  output logic              fifo_pop,
  output logic              tx_start,
  input  logic              tx_done,
  output logic              rx_start,
  input  logic              rx_byte_vld,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_eof,
  output logic              auth_vld,
  output logic [BYTE_W-1:0] auth_byte,
  output logic              auth_last,
  input  logic              auth_done,
  output logic              idle,
  output logic              irq_idle,
  output logic              err_wr,
  output logic              err_auth
);

  logic [1:0] rs_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ns = rs_q[1];

  seq_st_e st_q, st_d;
  logic    send_q, send_d;
  logic    tx_go, rx_go, auto_end, auth_bad;
  logic    frame_end, hdr_ok, lock, rx_active;
  logic    err_auth_en, err_auth_d;

  always_comb begin
    lock      = (st_q == ST_ACHK) || (st_q == ST_ASEND) || (st_q == ST_AWAIT);
    rx_active = (st_q == ST_RECV) || (st_q == ST_XRECV);
    idle      = (st_q == ST_IDLE);
  end

  rfcmd_rx_track u_track (
    .clk       (clk),
    .rst_n     (rst_ns),
    .active    (rx_active),
    .clear     (cmd_we),
    .len_mode  (len_mode),
    .byte_vld  (rx_byte_vld),
    .byte_in   (rx_byte),
    .eof       (rx_eof),
    .frame_end (frame_end)
  );

  rfcmd_auth_stream #(
    .LVL_W      (LVL_W),
    .AUTH_BYTES (AUTH_BYTES)
  ) u_auth (
    .clk        (clk),
    .rst_n      (rst_ns),
    .run        (st_q == ST_ASEND),
    .fifo_level (fifo_level),
    .fifo_head  (fifo_head),
    .hdr_ok     (hdr_ok),
    .auth_vld   (auth_vld),
    .auth_byte  (auth_byte),
    .auth_last  (auth_last),
    .fifo_pop   (fifo_pop)
  );

  rfcmd_host_guard u_guard (
    .clk     (clk),
    .rst_n   (rst_ns),
    .lock    (lock),
    .clr     (cmd_we),
    .host_rd (host_rd),
    .host_wr (host_wr),
    .rd_gnt  (host_rd_gnt),
    .wr_gnt  (host_wr_gnt),
    .err_wr  (err_wr)
  );

  always_comb begin
    st_d     = st_q;
    tx_go    = 1'b0;
    rx_go    = 1'b0;
    auto_end = 1'b0;
    auth_bad = 1'b0;
    if (cmd_we) begin
      case (cmd_code)
        CMD_RECV: begin st_d = ST_RECV; rx_go = 1'b1; end
        CMD_XCV:  st_d = ST_XWAIT;
        CMD_AUTH: st_d = ST_ACHK;
        default:  st_d = ST_IDLE;
      endcase
    end else begin
      case (st_q)
        ST_RECV:  if (frame_end && !multi_rx) begin st_d = ST_IDLE; auto_end = 1'b1; end
        ST_XWAIT: if (send_q) begin st_d = ST_XSEND; tx_go = 1'b1; end
        ST_XSEND: if (tx_done) begin st_d = ST_XRECV; rx_go = 1'b1; end
        ST_XRECV: if (frame_end && !multi_rx) st_d = ST_XWAIT;
        ST_ACHK: begin
          if (hdr_ok) st_d = ST_ASEND;
          else begin st_d = ST_IDLE; auth_bad = 1'b1; end
        end
        ST_ASEND: if (auth_last) st_d = ST_AWAIT;
        ST_AWAIT: if (auth_done) begin st_d = ST_IDLE; auto_end = 1'b1; end
        default:  st_d = ST_IDLE;
      endcase
    end
    send_d      = send_set | (send_q & ~tx_go);
    err_auth_en = auth_bad | cmd_we;
    err_auth_d  = auth_bad;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q     <= ST_IDLE;
      send_q   <= 1'b0;
      tx_start <= 1'b0;
      rx_start <= 1'b0;
      irq_idle <= 1'b0;
    end else begin
      st_q     <= st_d;
      send_q   <= send_d;
      tx_start <= tx_go;
      rx_start <= rx_go;
      irq_idle <= auto_end;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)          err_auth <= 1'b0;
    else if (err_auth_en) err_auth <= err_auth_d;
  end

  // R1
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0({tx_start, rx_start, irq_idle}));

  // R2
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    irq_idle |-> idle);

  // R2
  recv_end_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (st_q == ST_RECV && frame_end && !multi_rx && !cmd_we) |=> (irq_idle && idle));

  // R6
  send_clear_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    tx_start |-> (send_q == $past(send_set)));

  // R7
  tx_to_rx_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (st_q == ST_XSEND && tx_done && !cmd_we) |=> rx_start);

  // R9
  bad_hdr_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (st_q == ST_ACHK && !cmd_we && !hdr_ok) |=> (err_auth && idle && !auth_vld));

  // R13
  cmd_wins_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    cmd_we |=> !irq_idle);

endmodule

// File: tb/sim_rfcmd_seq.sv
`timescale 1ns/1ps
module sim_rfcmd_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [3:0] cmd_code = 4'h0;
  logic       send_set = 1'b0, multi_rx = 1'b0, len_mode = 1'b0;
  logic       host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [6:0] fifo_level = '0;
  logic [7:0] fifo_head = '0;
  logic       tx_done = 1'b0, rx_byte_vld = 1'b0, rx_eof = 1'b0, auth_done = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       host_rd_gnt, host_wr_gnt, fifo_pop, tx_start, rx_start;
  logic       auth_vld, auth_last, idle, irq_idle, err_wr, err_auth;
  logic [7:0] auth_byte;

  always #2 clk = ~clk;

  rfcmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_code(cmd_code),
    .send_set(send_set), .multi_rx(multi_rx), .len_mode(len_mode),
    .host_rd(host_rd), .host_wr(host_wr),
    .host_rd_gnt(host_rd_gnt), .host_wr_gnt(host_wr_gnt),
    .fifo_level(fifo_level), .fifo_head(fifo_head), .fifo_pop(fifo_pop),
    .tx_start(tx_start), .tx_done(tx_done), .rx_start(rx_start),
    .rx_byte_vld(rx_byte_vld), .rx_byte(rx_byte), .rx_eof(rx_eof),
    .auth_vld(auth_vld), .auth_byte(auth_byte), .auth_last(auth_last),
    .auth_done(auth_done), .idle(idle), .irq_idle(irq_idle),
    .err_wr(err_wr), .err_auth(err_auth)
  );

  int    errs = 0;
  int    checks = 0;
  string cur_req = "R1";
  bit    done_f = 1'b0;

  // behavioural reference: 0 idle, 1 recv, 2 wait-send, 3 sending,
  // 4 loop-recv, 5 auth-check, 6 auth-stream, 7 auth-wait
  int  m_st = 0;
  bit  m_send = 0, m_errw = 0, m_erra = 0, m_have = 0;
  int  m_rem = 0, m_cnt = 0;
  bit  e_tx = 0, e_rx = 0, e_irq = 0;
  int  fq[$];
  logic [6:0] nxt_level = '0;
  logic [7:0] nxt_head = '0;

  always @(posedge clk) begin
    fifo_level <= nxt_level;
    fifo_head  <= nxt_head;
  end

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit lk;
    lk = (m_st >= 5);
    chk("idle", {7'd0, idle}, {7'd0, m_st == 0});
    chk("tx_start", {7'd0, tx_start}, {7'd0, e_tx});
    chk("rx_start", {7'd0, rx_start}, {7'd0, e_rx});
    chk("irq_idle", {7'd0, irq_idle}, {7'd0, e_irq});
    chk("err_wr", {7'd0, err_wr}, {7'd0, m_errw});
    chk("err_auth", {7'd0, err_auth}, {7'd0, m_erra});
    chk("auth_vld", {7'd0, auth_vld}, {7'd0, m_st == 6});
    chk("fifo_pop", {7'd0, fifo_pop}, {7'd0, m_st == 6});
    chk("auth_last", {7'd0, auth_last}, {7'd0, (m_st == 6) && (m_cnt == 11)});
    if (m_st == 6) chk("auth_byte", auth_byte, nxt_head);
    chk("host_rd_gnt", {7'd0, host_rd_gnt}, {7'd0, host_rd && !lk});
    chk("host_wr_gnt", {7'd0, host_wr_gnt}, {7'd0, host_wr && !lk});
  endtask

  task automatic model_step();
    bit lk, act, fe, bad, ntx, nrx, nirq;
    int nx;
    lk  = (m_st >= 5);
    act = (m_st == 1) || (m_st == 4);
    if (len_mode) fe = act && rx_byte_vld && (m_have ? (m_rem == 1) : (rx_byte == 8'd0));
    else          fe = act && rx_eof;
    nx = m_st; ntx = 0; nrx = 0; nirq = 0; bad = 0;
    if (cmd_we) begin
      if (cmd_code == 4'h8) begin nx = 1; nrx = 1; end
      else if (cmd_code == 4'hC) nx = 2;
      else if (cmd_code == 4'hE) nx = 5;
      else nx = 0;
    end else begin
      case (m_st)
        1: if (fe && !multi_rx) begin nx = 0; nirq = 1; end
        2: if (m_send) begin nx = 3; ntx = 1; end
        3: if (tx_done) begin nx = 4; nrx = 1; end
        4: if (fe && !multi_rx) nx = 2;
        5: if (fq.size() >= 12 && (fq[0] == 8'h60 || fq[0] == 8'h61)) nx = 6;
           else begin nx = 0; bad = 1; end
        6: if (m_cnt == 11) nx = 7;
        7: if (auth_done) begin nx = 0; nirq = 1; end
        default: ;
      endcase
    end
    if (cmd_we || !act || fe) m_have = 0;
    else if (len_mode && rx_byte_vld) begin
      if (!m_have) begin m_have = 1; m_rem = int'(rx_byte); end
      else m_rem = m_rem - 1;
    end
    m_cnt  = (m_st == 6) ? m_cnt + 1 : 0;
    m_send = send_set || (m_send && !ntx);
    if (lk && (host_rd || host_wr)) m_errw = 1;
    else if (cmd_we) m_errw = 0;
    if (bad) m_erra = 1;
    else if (cmd_we) m_erra = 0;
    if (((m_st == 6) || (host_rd && !lk)) && fq.size() > 0) void'(fq.pop_front());
    if (host_wr && !lk) fq.push_back(int'(host_wdata));
    m_st = nx; e_tx = ntx; e_rx = nrx; e_irq = nirq;
    nxt_level = 7'(fq.size());
    nxt_head  = (fq.size() > 0) ? 8'(fq[0]) : 8'h00;
  endtask

  task automatic step();
    model_step();
    @(negedge clk);
    compare_all();
    #1;
    cmd_we = 0; send_set = 0; host_rd = 0; host_wr = 0;
    rx_byte_vld = 0; rx_eof = 0; tx_done = 0; auth_done = 0;
  endtask

  task automatic idle_cyc(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr_cmd(logic [3:0] c);
    cmd_code = c; cmd_we = 1; step();
  endtask

  task automatic fill(int n, logic [7:0] first);
    for (int i = 0; i < n; i++) begin
      host_wr = 1;
      host_wdata = (i == 0) ? first : 8'(i * 7 + 3);
      step();
    end
  endtask

  task automatic flush(int n);
    for (int i = 0; i < n; i++) begin host_rd = 1; step(); end
  endtask

  task automatic rx_b(logic [7:0] b);
    rx_byte_vld = 1; rx_byte = b; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";          // reset state
    compare_all();
    #1 rst_n = 1'b1;
    idle_cyc(4);
    // R1: idle and unknown codes
    wr_cmd(4'h0); idle_cyc(2);
    wr_cmd(4'h5); idle_cyc(2);
    wr_cmd(4'hF); idle_cyc(1);
    // R2: receive ended by end-of-frame strobe
    cur_req = "R2";
    wr_cmd(4'h8); idle_cyc(3);
    rx_eof = 1; step(); idle_cyc(3);
    // R3: length-byte frames, strobe ignored
    cur_req = "R3";
    len_mode = 1;
    wr_cmd(4'h8); idle_cyc(2);
    rx_b(8'd3);
    rx_eof = 1; step();
    rx_b(8'hAA); rx_b(8'h55); idle_cyc(1); rx_b(8'h11);
    idle_cyc(2);
    wr_cmd(4'h8); idle_cyc(1);
    rx_b(8'd0); idle_cyc(2);
    len_mode = 0;
    // R4: multi-frame receive never ends alone
    cur_req = "R4";
    multi_rx = 1;
    wr_cmd(4'h8); idle_cyc(2);
    rx_eof = 1; step(); idle_cyc(2);
    rx_eof = 1; step(); idle_cyc(2);
    wr_cmd(4'h0); idle_cyc(2);
    multi_rx = 0;
    // R13: command write meets frame end
    cur_req = "R13";
    wr_cmd(4'h8); idle_cyc(2);
    rx_eof = 1; cmd_code = 4'hC; cmd_we = 1; step(); idle_cyc(2);
    wr_cmd(4'h0); idle_cyc(1);
    // R5: transceive waits for start-send
    cur_req = "R5";
    wr_cmd(4'hC); idle_cyc(4);
    send_set = 1; step(); idle_cyc(2);
    // R7: loop back to waiting after a frame
    cur_req = "R7";
    idle_cyc(2);
    tx_done = 1; step(); idle_cyc(2);
    rx_eof = 1; step(); idle_cyc(3);
    // R6: set coinciding with a launch is kept
    cur_req = "R6";
    send_set = 1; step();
    send_set = 1; step(); idle_cyc(2);
    tx_done = 1; step(); idle_cyc(1);
    rx_eof = 1; step(); idle_cyc(3);
    tx_done = 1; step(); idle_cyc(1);
    rx_eof = 1; step(); idle_cyc(3);
    wr_cmd(4'h0); idle_cyc(1);
    // R8: transceive with multi-frame stays receiving
    cur_req = "R8";
    multi_rx = 1;
    wr_cmd(4'hC); send_set = 1; step(); idle_cyc(2);
    tx_done = 1; step(); idle_cyc(2);
    rx_eof = 1; step(); idle_cyc(2);
    send_set = 1; step(); idle_cyc(3);
    wr_cmd(4'h0); idle_cyc(2);
    multi_rx = 0;
    // R9: too few bytes, then a wrong first byte
    cur_req = "R9";
    fill(5, 8'h60);
    wr_cmd(4'hE); idle_cyc(3);
    cur_req = "R12";
    idle_cyc(2);
    wr_cmd(4'h0); idle_cyc(1);
    flush(5);
    cur_req = "R9";
    fill(12, 8'h55);
    wr_cmd(4'hE); idle_cyc(2);
    flush(12);
    wr_cmd(4'h0);
    // R11 and R10: good authentication with host access locked out
    cur_req = "R11";
    fill(12, 8'h61);
    wr_cmd(4'hE);
    host_rd = 1; step();
    idle_cyc(3);
    host_wr = 1; host_wdata = 8'hEE; step();
    cur_req = "R10";
    idle_cyc(12);
    auth_done = 1; step(); idle_cyc(2);
    cur_req = "R11";
    host_wr = 1; host_wdata = 8'h01; step();
    host_rd = 1; step();
    cur_req = "R12";
    idle_cyc(2);
    wr_cmd(4'h0); idle_cyc(1);
    // R13: command write meets auth_done, error set meets clear
    cur_req = "R13";
    fill(12, 8'h60);
    wr_cmd(4'hE); idle_cyc(16);
    auth_done = 1; cmd_code = 4'h0; cmd_we = 1; host_wr = 1; host_wdata = 8'h77; step();
    idle_cyc(2);
    wr_cmd(4'h0); idle_cyc(2);
    done_f = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_f) begin
      checks++;
      errs++;
      $display("FAIL %s watchdog: actual=running expected=finished", cur_req);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule